// File: doc/BRIEF.md
# Glitchless Synchronous Clock Gate

This block turns a free-running square wave on or off without cutting a pulse short and without letting a partial pulse through. A system clock samples the square wave, which must run at least four times slower, and resynchronizes it. The result drives a complementary pair of gated outputs. An active-high disable input controls the gate. The gate reads the disable input only while the sampled wave is low. Because of this, a high phase already in progress always runs to its end, and a high phase that has not begun is either passed whole or suppressed whole.

A separate ungated output always carries the inverse of the sampled wave. The disable input has no effect on it. A typical use sits after an oscillator that is never stopped: a counter downstream then sees an exact number of complete cycles for each enabled window.

Top module: `osc_gate`

## Requirements
- R1: While the disable input is low, the gated true output equals the wave input and the gated complement equals its inverse. Every output reflects its inputs with a latency of three system clock edges (two synchronizer stages and one output register).
- R2: If the disable input rises while the wave is high, that high pulse still appears at full length on the gated true output. The gated true output goes low and stays low from the wave's next falling edge.
- R3: If the disable input rises while the wave is low, the next high phase of the wave is suppressed completely: the gated true output stays low and the complement stays high.
- R4: The gated outputs stay in the disabled state (true low, complement high) for as long as the disable input stays high.
- R5: Clearing the disable input takes effect only while the wave is low. A release during a high phase leaves that high phase suppressed, and the first gated pulse after a release is a complete high phase.
- R6: The ungated output is the inverse of the wave input at all times, whatever the disable input does.
- R7: A synchronous active-high reset clears the captured disable. After reset the outputs are true 0, complement 1, ungated 1, which is the state for a low wave.
- R8: The gated complement output is the inverse of the gated true output on every cycle.
- R9: Every high pulse on the gated true output lasts exactly one full high phase of the wave, so no runt pulse is ever produced. The number of gated rising edges equals the number of wave high phases that were not suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_in | input | 1 | Free-running square wave to be gated (asynchronous) |
| gate_off | input | 1 | Active-high disable request (asynchronous) |
| gated_q | output | 1 | Gated true output |
| gated_qn | output | 1 | Gated complement output |
| wave_inv | output | 1 | Ungated inverse of the wave |

## Verification
The bench places disable edges deliberately inside high phases and inside low phases, both when asserting and when releasing. A design that captured the disable input at any time would clip the running pulse (R2), would let a pulse leak through after a release in mid-high (R5), or would gate the wrong pulse after a request in mid-low (R3). Long randomized runs with half-periods near the four-to-one limit count the gated rising edges and measure each gated pulse, so an extra count or a shortened pulse is caught even where it coincides with a change in the disable input.

// File: rtl/osc_gate_pkg.sv
package osc_gate_pkg;

    // Default synchronizer depth for asynchronous inputs
    localparam int SYNC_DEPTH_DEF = 2;

    // Sampled inputs carried through the synchronizer as one word
    typedef struct packed {
        logic wave;
        logic off;
    } gate_in_t;

    localparam int GATE_IN_W = $bits(gate_in_t);

    // Registered output bundle
    typedef struct packed {
        logic q;
        logic qn;
        logic inv;
    } gate_out_t;

    // Output state that matches a low wave
    localparam gate_out_t GATE_OUT_IDLE = '{q: 1'b0, qn: 1'b1, inv: 1'b1};

    // Output word formed from the sampled wave and the captured disable
    function automatic gate_out_t form_out(input logic wave, input logic held_off);
        gate_out_t o;
        o.q   = wave & ~held_off;
        o.qn  = ~o.q;
        o.inv = ~wave;
        return o;
    endfunction

endpackage

// File: rtl/osc_gate_sync.sv
module osc_gate_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/osc_gate_hold.sv
module osc_gate_hold (
    input  logic clk,
    input  logic rst,
    input  logic wave,
    input  logic off,
    output logic held_off
);
    // Disable is captured only during the low phase of the sampled wave
    always_ff @(posedge clk) begin
        if (rst)        held_off <= 1'b0;
        else if (!wave) held_off <= off;
    end

    // R2 / R5: captured disable cannot change while the wave is high
    hold_frozen_high_chk: assert property (@(posedge clk) disable iff (rst)
        wave |=> $stable(held_off));

    // R3: a request seen during a low phase is captured for the next pulse
    hold_capture_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!wave && off) |=> held_off);
endmodule

// File: rtl/osc_gate_out.sv
module osc_gate_out
    import osc_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wave,
    input  logic      held_off,
    output gate_out_t o
);
    always_ff @(posedge clk) begin
        if (rst) o <= GATE_OUT_IDLE;
        else     o <= form_out(wave, held_off);
    end

    // R1
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wave && !held_off) |=> (o.q && !o.qn));

    // R4
    out_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        held_off |=> (!o.q && o.qn));

    // R6
    out_inv_low_chk: assert property (@(posedge clk) disable iff (rst)
        !wave |=> o.inv);

    // R6
    out_inv_high_chk: assert property (@(posedge clk) disable iff (rst)
        wave |=> !o.inv);
endmodule

// File: rtl/osc_gate.sv
module osc_gate
    import osc_gate_pkg::*;
#(
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic wave_in,
    input  logic gate_off,
    output logic gated_q,
    output logic gated_qn,
    output logic wave_inv
);
    gate_in_t  raw_in;
    gate_in_t  syn_in;
    logic      held_off;
    gate_out_t out_w;

    assign raw_in.wave = wave_in;
    assign raw_in.off  = gate_off;

    osc_gate_sync #(
        .WIDTH  (GATE_IN_W),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    osc_gate_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .wave     (syn_in.wave),
        .off      (syn_in.off),
        .held_off (held_off)
    );

    osc_gate_out u_out (
        .clk      (clk),
        .rst      (rst),
        .wave     (syn_in.wave),
        .held_off (held_off),
        .o        (out_w)
    );

    assign gated_q  = out_w.q;
    assign gated_qn = out_w.qn;
    assign wave_inv = out_w.inv;

    // R9: a gated pulse may only begin when the sampled wave was already high
    top_no_runt_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gated_q) |-> $past(syn_in.wave));
endmodule

// File: tb/osc_gate_tb.sv
module osc_gate_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wave_in = 1'b0;
    logic gate_off = 1'b0;
    logic gated_q, gated_qn, wave_inv;

    always #2 clk = ~clk;

    osc_gate u_dut (
        .clk      (clk),
        .rst      (rst),
        .wave_in  (wave_in),
        .gate_off (gate_off),
        .gated_q  (gated_q),
        .gated_qn (gated_qn),
        .wave_inv (wave_inv)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    logic  cur_off = 1'b0;

    // Reference model state, written from the requirements
    logic  m_held = 1'b0;
    logic [2:0] e0 = 3'b011, e1 = 3'b011, e2 = 3'b011; // {q, qn, inv}
    int    run_len = 0;
    int    rises = 0;
    int    exp_rises = 0;
    logic  prev_q = 1'b0;
    logic  prev_eq = 1'b0;
    localparam int MIN_HALF = 2;

    function automatic logic [2:0] model_out(input logic w, input logic held);
        logic q;
        q = w & ~held;
        return {q, ~q, ~w};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One system cycle: compare outputs, then drive new inputs
    task automatic step(input logic w, input logic off);
        @(negedge clk);
        check(cur_req, gated_q, e2[2]);
        check("R8", gated_qn, ~gated_q);
        check("R6", wave_inv, e2[0]);
        // R9: pulse accounting on the observed gated output
        if (gated_q && !prev_q) rises++;
        if (e2[2] && !prev_eq) exp_rises++;
        if (gated_q) run_len++;
        else if (prev_q) begin
            n_chk++;
            if (run_len < MIN_HALF) begin
                n_fail++;
                $display("FAIL R9: actual pulse %0d expected >= %0d", run_len, MIN_HALF);
            end
            run_len = 0;
        end
        prev_q  = gated_q;
        prev_eq = e2[2];
        e2 = e1;
        e1 = e0;
        wave_in  = w;
        gate_off = off;
        e0 = model_out(w, m_held);
        if (!w) m_held = off;
    endtask

    // One phase of the wave; the disable input changes to new_off at index at
    task automatic phase(input logic lvl, input int len, input int at, input logic new_off);
        for (int i = 0; i < len; i++) begin
            if (i == at) cur_off = new_off;
            step(lvl, cur_off);
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h0000_51ed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7", gated_q, 1'b0);
        check("R7", gated_qn, 1'b1);
        check("R7", wave_inv, 1'b1);
        rst = 1'b0;

        cur_req = "R1";
        for (int k = 0; k < 4; k++) begin
            phase(1'b1, 3 + k, 99, 1'b0);
            phase(1'b0, 3 + k, 99, 1'b0);
        end

        cur_req = "R2";
        phase(1'b1, 6, 3, 1'b1);   // request mid-high: pulse completes
        phase(1'b0, 5, 99, 1'b1);
        cur_req = "R4";
        phase(1'b1, 5, 99, 1'b1);
        phase(1'b0, 5, 99, 1'b1);
        cur_req = "R5";
        phase(1'b1, 6, 2, 1'b0);   // release mid-high: still blocked
        phase(1'b0, 5, 99, 1'b0);
        phase(1'b1, 5, 99, 1'b0);  // first full pulse
        phase(1'b0, 6, 99, 1'b0);

        cur_req = "R3";
        phase(1'b0, 6, 3, 1'b1);   // request mid-low: next pulse gone
        phase(1'b1, 5, 99, 1'b1);
        phase(1'b0, 6, 3, 1'b0);   // release mid-low
        cur_req = "R5";
        phase(1'b1, 5, 99, 1'b0);
        phase(1'b0, 5, 99, 1'b0);

        cur_req = "R9";
        for (int k = 0; k < 500; k++) begin
            int hl, ll, at;
            hl = 2 + int'($urandom_range(5));
            ll = 2 + int'($urandom_range(5));
            at = int'($urandom_range(6));
            phase(1'b1, hl, at, ($urandom_range(3) == 0) ? ~cur_off : cur_off);
            at = int'($urandom_range(6));
            phase(1'b0, ll, at, ($urandom_range(3) == 0) ? ~cur_off : cur_off);
        end
        phase(1'b0, 6, 0, 1'b0);

        // R9: gated rising edges equal unsuppressed wave high phases
        n_chk++;
        if (rises != exp_rises) begin
            n_fail++;
            $display("FAIL R9: actual %0d rises expected %0d", rises, exp_rises);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule